// File: doc/BRIEF.md
# Zero-Crossing Signal Quality Detector

This block rates the quality of a received binary baseband stream by timing. A clock-recovery loop elsewhere gives it a phase count that runs through 64 steps per bit. It also gives a strobe that marks each detected zero crossing of the data waveform. On every strobe the block reads the phase count and decides whether the crossing arrived close enough to the predicted point, which is phase 0. The crossing is then good or bad.

The block drives a one-bit quality flag. The flag goes high only after an unbroken run of good crossings. A single bad crossing pulls it low. The flag changes only on rising edges of the recovered bit clock, so it stays aligned with the received data. Logic outside the block is expected to average the flag to estimate signal-to-noise ratio. The detector has no hold input, so freezing the clock and level loops does not stop it. While the receiver is in powersave, the flag is forced to 0.

Top module: `sq_detect`

## Requirements
- R1: A crossing is good when its phase count (6 bits, 64 steps per bit, predicted point 0) is 0..8 or 56..63. Any other phase (9..55) makes it bad.
- R2: After 4 consecutive good crossings, the flag is high from the first bit-clock rising edge that follows.
- R3: With fewer than 4 consecutive good crossings since the last bad crossing or clear, the flag stays low at a bit-clock rising edge.
- R4: A bad crossing resets the good-run count to zero. The flag is then low from the next bit-clock rising edge. A strobe that coincides with that edge counts toward that edge's decision.
- R5: The flag holds its value between bit-clock rising edges, whatever crossings arrive in between. A rising edge is seen in the first clock cycle where bitClk is 1 after a cycle where it was 0. The flag takes its new value at the end of that cycle.
- R6: The good-run count saturates. Any number of further good crossings keeps the flag high across many bit-clock edges.
- R7: While rxPs is 1, qualityFlag is 0 in the same cycle, and the run count and flag register are cleared. After release, 4 new good crossings are needed.
- R8: A synchronous active-high reset clears the run count and drives the flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| xingStb | input | 1 | One-cycle strobe marking a zero crossing |
| xingPhase | input | 6 | Recovered-clock phase count at the crossing |
| bitClk | input | 1 | Recovered bit clock, sampled in the clk domain |
| rxPs | input | 1 | Receiver powersave; forces the flag to 0 |
| qualityFlag | output | 1 | Signal quality flag |

## Verification
A crossing strobe changes only the internal run count. The count has no visible effect until the bit clock rises. The flag then changes at the clock edge that ends the first cycle with bitClk high. The bench drives every input on the falling clock edge. It samples the flag one nanosecond after the rising edge that closes the bit-clock cycle. It also samples just before that cycle, to confirm the flag has not moved early. Powersave is the one combinational path. The bench checks it within the same cycle in which rxPs is raised.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // Strobes passed from control to datapath
  typedef struct packed {
    logic clear;   // wipe run count and flag
    logic sample;  // bit-clock rising edge: update flag
  } sqCtrl_t;
endpackage

// File: rtl/sq_ctrl.sv
module sq_ctrl
  import sq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    bitClk,
  input  logic    rxPs,
  output sqCtrl_t ctrl
);
  logic bitClkQ;

  always_ff @(posedge clk) begin
    if (rst) bitClkQ <= 1'b0;
    else     bitClkQ <= bitClk;
  end

  always_comb begin
    ctrl.clear  = rst | rxPs;
    ctrl.sample = bitClk & ~bitClkQ;
  end

  // R5: a sample strobe never appears in two cycles back to back
  a_r5_single_sample: assert property (@(posedge clk) disable iff (rst)
    ctrl.sample |=> !ctrl.sample);
endmodule

// File: rtl/sq_dpath.sv
module sq_dpath
  import sq_pkg::*;
#(
  parameter int PHASE_W = 6,
  parameter int TOL     = 8,
  parameter int RUN_LEN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  sqCtrl_t            ctrl,
  input  logic               xingStb,
  input  logic [PHASE_W-1:0] xingPhase,
  output logic               flagQ
);
  localparam int PHASES = 1 << PHASE_W;
  localparam int RUN_W  = $clog2(RUN_LEN + 1);
  localparam logic [PHASE_W-1:0] LO_EDGE = PHASE_W'(TOL);
  localparam logic [PHASE_W-1:0] HI_EDGE = PHASE_W'(PHASES - TOL);
  localparam logic [RUN_W-1:0]   RUN_MAX = RUN_W'(RUN_LEN);

  logic             isGood;
  logic [RUN_W-1:0] runCnt, runNext;

  // Phase error measured around the predicted point 0, wrapping
  assign isGood = (xingPhase <= LO_EDGE) || (xingPhase >= HI_EDGE);

  always_comb begin
    runNext = runCnt;
    if (ctrl.clear)      runNext = '0;
    else if (xingStb) begin
      if (!isGood)                 runNext = '0;
      else if (runCnt != RUN_MAX)  runNext = runCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    runCnt <= runNext;
    if (ctrl.clear)       flagQ <= 1'b0;
    else if (ctrl.sample) flagQ <= (runNext == RUN_MAX);
  end

  // R4: a crossing in the bad window leaves the run count at zero
  a_r4_bad_resets: assert property (@(posedge clk) disable iff (rst)
    (xingStb && xingPhase > LO_EDGE && xingPhase < HI_EDGE) |=> (runCnt == '0));
  // R5: flag moves only on a sample or clear strobe
  a_r5_flag_steady: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.sample && !ctrl.clear) |=> $stable(flagQ));
  // R6: run count never passes its ceiling
  a_r6_saturate: assert property (@(posedge clk) disable iff (rst)
    runCnt <= RUN_MAX);
  // R7: clear empties count and flag
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    ctrl.clear |=> (runCnt == '0 && !flagQ));
  // R2: full run with no crossing at a sample raises the flag
  a_r2_raise: assert property (@(posedge clk) disable iff (rst)
    (ctrl.sample && !ctrl.clear && !xingStb && runCnt == RUN_MAX) |=> flagQ);
endmodule

// File: rtl/sq_detect.sv
module sq_detect
  import sq_pkg::*;
#(
  parameter int PHASE_W = 6,
  parameter int TOL     = 8,
  parameter int RUN_LEN = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               xingStb,
  input  logic [PHASE_W-1:0] xingPhase,
  input  logic               bitClk,
  input  logic               rxPs,
  output logic               qualityFlag
);
  sqCtrl_t ctrl;
  logic    flagQ;

  sq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .bitClk(bitClk), .rxPs(rxPs), .ctrl(ctrl)
  );

  sq_dpath #(.PHASE_W(PHASE_W), .TOL(TOL), .RUN_LEN(RUN_LEN)) u_dpath (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .xingStb(xingStb), .xingPhase(xingPhase), .flagQ(flagQ)
  );

  // Powersave masks the flag at once; the register clears a cycle later
  assign qualityFlag = flagQ & ~rxPs;
endmodule

// File: tb/sq_detect_tb.sv
module sq_detect_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xingStb = 1'b0;
  logic [5:0] xingPhase = '0;
  logic       bitClk = 1'b0;
  logic       rxPs = 1'b0;
  logic       qualityFlag;
  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sq_detect u_dut (
    .clk(clk), .rst(rst), .xingStb(xingStb), .xingPhase(xingPhase),
    .bitClk(bitClk), .rxPs(rxPs), .qualityFlag(qualityFlag)
  );

  task automatic chk(input logic exp, input string req);
    total++;
    if (qualityFlag !== exp) begin
      bad++;
      $display("FAIL %s: qualityFlag=%b expected=%b", req, qualityFlag, exp);
    end
  endtask

  task automatic xing(input int ph);
    @(negedge clk);
    xingStb = 1'b1; xingPhase = 6'(ph);
    @(negedge clk);
    xingStb = 1'b0;
  endtask

  // Raise bitClk for one cycle; sample after the edge that closes it
  task automatic bitRise(input logic exp, input string req);
    @(negedge clk);
    bitClk = 1'b1;
    @(posedge clk); #1;
    chk(exp, req);
    @(negedge clk);
    bitClk = 1'b0;
  endtask

  task automatic t_reset;
    #1 chk(1'b0, "R8 during reset");
    bitRise(1'b0, "R8 after reset");
  endtask

  task automatic t_short_run;
    xing(0); xing(3); xing(60);
    bitRise(1'b0, "R3 three goods");
  endtask

  task automatic t_full_run;
    xing(1);
    #1 chk(1'b0, "R5 before edge");
    bitRise(1'b1, "R2 fourth good");
  endtask

  task automatic t_window;
    xing(9);
    bitRise(1'b0, "R4 phase 9 bad");
    xing(8); xing(56); xing(63); xing(0);
    bitRise(1'b1, "R1 window edges good");
    xing(55);
    #1 chk(1'b1, "R5 held after bad");
    bitRise(1'b0, "R4 phase 55 bad");
    xing(32); xing(2); xing(2); xing(2);
    bitRise(1'b0, "R1 phase 32 bad then 3 goods");
  endtask

  task automatic t_coincide;
    xing(0); xing(0); xing(0); xing(0);
    bitRise(1'b1, "R2 run before coincide");
    // Bad strobe in the same cycle as the rising bit clock
    @(negedge clk);
    bitClk = 1'b1; xingStb = 1'b1; xingPhase = 6'd20;
    @(posedge clk); #1;
    chk(1'b0, "R4 coincident bad");
    @(negedge clk);
    bitClk = 1'b0; xingStb = 1'b0;
  endtask

  task automatic t_saturate;
    for (int i = 0; i < 10; i++) xing(4);
    bitRise(1'b1, "R6 ten goods");
    for (int i = 0; i < 3; i++) begin
      xing(62);
      bitRise(1'b1, "R6 stays high");
    end
  endtask

  task automatic t_powersave;
    @(negedge clk);
    rxPs = 1'b1;
    #1 chk(1'b0, "R7 immediate mask");
    bitRise(1'b0, "R7 during powersave");
    @(negedge clk);
    rxPs = 1'b0;
    #1 chk(1'b0, "R7 after release");
    xing(0); xing(0); xing(0);
    bitRise(1'b0, "R7 three goods after release");
    xing(0);
    bitRise(1'b1, "R7 four goods after release");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_short_run();
    t_full_run();
    t_window();
    t_coincide();
    t_saturate();
    t_powersave();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    total++; bad++;
    $display("FAIL watchdog: run did not end");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule